// File: doc/BRIEF.md
# DMA Request Generator for a Buffered Serial Port

This block produces the two active-low DMA request lines of a serial port that has receive and transmit FIFOs. One line asks a DMA engine to read characters. The other asks it to write characters. The block sees only the occupancy counts and a few status flags; the FIFOs, the trigger-level compare and the character timeout live elsewhere and arrive as inputs.

Two request styles are supported. The first is single-transfer, where a request follows the current occupancy directly. The second is multi-transfer, where a request latches and keeps the DMA engine busy until the FIFO has been fully drained (receive side) or fully filled (transmit side). Multi-transfer applies only when the FIFO-enable bit and the DMA-select bit are both set. With FIFOs disabled, the port behaves as a one-character holding register and only single-transfer signalling exists.

Both outputs are registered, so each responds one clock after its inputs. A change of the mode bits discards any latched request, and the outputs are then recomputed from the present counts.

Top module: `dma_ready_gen`

## Requirements
- R1: After reset, both `rx_req_n` and `tx_req_n` are 1 (inactive).
- R2: Multi-transfer mode is in force only when `fifo_en`=1 and `dma_sel`=1; every other combination selects single-transfer.
- R3: In single-transfer mode, `rx_req_n` equals 0 one clock after `rx_count`>0 and equals 1 one clock after `rx_count`=0.
- R4: In single-transfer mode, `tx_req_n` equals 0 one clock after `tx_count`=0 and equals 1 one clock after `tx_count`>0.
- R5: In multi-transfer mode, `rx_req_n` goes to 0 one clock after `rx_trig_hit`=1 or `rx_tmo_hit`=1, while `rx_count`>0.
- R6: In multi-transfer mode, once `rx_req_n` is 0 it stays 0 while `rx_count`>0, even with the trigger and timeout flags at 0. It returns to 1 one clock after `rx_count`=0.
- R7: In multi-transfer mode, `tx_req_n` goes to 0 one clock after `tx_count`=0. It stays 0 until `tx_count`=TX_DEPTH, and returns to 1 one clock after that. Once at 1, it stays 1 until `tx_count` is 0 again.
- R8: With `fifo_en`=0 (compatibility mode), `dma_sel` has no effect: the outputs follow R3 and R4.
- R9: A change of `fifo_en` or `dma_sel` clears any latched multi-transfer request in the same clock. The next output values are computed from the current counts and flags, as if no request had been latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_count | input | $clog2(RX_DEPTH+1) | Characters held in the receive FIFO or holding register |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_tmo_hit | input | 1 | Receive character timeout reached |
| tx_count | input | $clog2(TX_DEPTH+1) | Characters held in the transmit FIFO or holding register |
| fifo_en | input | 1 | FIFO enable bit of the FIFO control register |
| dma_sel | input | 1 | DMA mode select bit of the FIFO control register |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
The hardest case to reach is clearing a latched receive request on a mode change. To make it visible, the request must be latched while the count is above zero and both flags are low, so that a stale latch would hold the line low. The bench first latches a multi-transfer receive request and drops the trigger. It then spends one clock in single-transfer mode, where the line stays low because characters remain, and then returns to multi-transfer mode. At that point a correct design raises the line, and one that kept its latch leaves it low. The same round trip is also made by toggling the FIFO enable instead of the DMA select.

// File: rtl/dma_ready_pkg.sv
package dma_ready_pkg;
   typedef enum logic {
      XFER_SINGLE = 1'b0,
      XFER_MULTI  = 1'b1
   } xfer_mode_e;

   typedef struct packed {
      logic fifo_en;
      logic dma_sel;
   } mode_bits_t;
endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
   import dma_ready_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fifo_en,
   input  logic       dma_sel,
   output xfer_mode_e mode,
   output logic       mode_chg
);
   mode_bits_t cur_bits;
   mode_bits_t prev_bits;

   assign cur_bits = '{fifo_en: fifo_en, dma_sel: dma_sel};

   // Multi-transfer only with both bits set; compatibility mode falls to single.
   assign mode = (fifo_en && dma_sel) ? XFER_MULTI : XFER_SINGLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_bits <= '0;
      else        prev_bits <= cur_bits;
   end

   assign mode_chg = (cur_bits != prev_bits);
endmodule

// File: rtl/dma_req_track.sv
module dma_req_track
   import dma_ready_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  xfer_mode_e mode,
   input  logic       flush,
   input  logic       set_cond,
   input  logic       keep_cond,
   input  logic       single_cond,
   output logic       req_n
);
   logic active_q;
   logic hold;
   logic active_d;

   assign hold = active_q && !flush;

   always_comb begin
      if (mode == XFER_MULTI) active_d = hold ? keep_cond : set_cond;
      else                    active_d = single_cond;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active_d;
   end

   assign req_n = !active_q;
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
   import dma_ready_pkg::*;
#(
   parameter int RX_DEPTH = 16,
   parameter int TX_DEPTH = 16,
   localparam int RXC_W = $clog2(RX_DEPTH + 1),
   localparam int TXC_W = $clog2(TX_DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RXC_W-1:0] rx_count,
   input  logic             rx_trig_hit,
   input  logic             rx_tmo_hit,
   input  logic [TXC_W-1:0] tx_count,
   input  logic             fifo_en,
   input  logic             dma_sel,
   output logic             rx_req_n,
   output logic             tx_req_n
);
   localparam int NUM_CH = 2;
   localparam int CH_RX  = 0;
   localparam int CH_TX  = 1;
   localparam logic [TXC_W-1:0] TX_FULL = TXC_W'(TX_DEPTH);

   generate
      if (RX_DEPTH < 1) begin : g_bad_rx
         $error("RX_DEPTH must be at least 1");
      end
      if (TX_DEPTH < 1) begin : g_bad_tx
         $error("TX_DEPTH must be at least 1");
      end
   endgenerate

   xfer_mode_e mode;
   logic       mode_chg;

   dma_mode_decode i_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_en  (fifo_en),
      .dma_sel  (dma_sel),
      .mode     (mode),
      .mode_chg (mode_chg)
   );

   logic [NUM_CH-1:0] set_c;
   logic [NUM_CH-1:0] keep_c;
   logic [NUM_CH-1:0] single_c;
   logic [NUM_CH-1:0] req_n_w;

   // Receive: latch on trigger/timeout, release when drained.
   assign set_c[CH_RX]    = rx_trig_hit || rx_tmo_hit;
   assign keep_c[CH_RX]   = (rx_count != '0);
   assign single_c[CH_RX] = (rx_count != '0);
   // Transmit: latch on empty, release when full.
   assign set_c[CH_TX]    = (tx_count == '0);
   assign keep_c[CH_TX]   = (tx_count != TX_FULL);
   assign single_c[CH_TX] = (tx_count == '0);

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         dma_req_track i_track (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode        (mode),
            .flush       (mode_chg),
            .set_cond    (set_c[ch]),
            .keep_cond   (keep_c[ch]),
            .single_cond (single_c[ch]),
            .req_n       (req_n_w[ch])
         );
      end
   endgenerate

   assign rx_req_n = req_n_w[CH_RX];
   assign tx_req_n = req_n_w[CH_TX];
endmodule

// File: rtl/dma_ready_chk.sv
module dma_ready_chk #(
   parameter int RX_DEPTH = 16,
   parameter int TX_DEPTH = 16,
   localparam int RXC_W = $clog2(RX_DEPTH + 1),
   localparam int TXC_W = $clog2(TX_DEPTH + 1)
)(
   input logic             clk,
   input logic             rst_n,
   input logic [RXC_W-1:0] rx_count,
   input logic             rx_trig_hit,
   input logic             rx_tmo_hit,
   input logic [TXC_W-1:0] tx_count,
   input logic             fifo_en,
   input logic             dma_sel,
   input logic             rx_req_n,
   input logic             tx_req_n
);
   logic multi;
   assign multi = fifo_en && dma_sel;

   always_comb begin
      if (!rst_n) begin
         p_reset_idle_r1: assert (rx_req_n && tx_req_n);
      end
   end

   // R2, R3, R8
   p_single_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !multi |=> (rx_req_n == ($past(rx_count) == '0)));

   // R2, R4, R8
   p_single_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !multi |=> (tx_req_n == ($past(tx_count) != '0)));

   p_multi_rx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && (rx_trig_hit || rx_tmo_hit) && rx_count != '0) |=> !rx_req_n);

   p_multi_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && $stable(fifo_en) && $stable(dma_sel) && !rx_req_n && rx_count != '0)
      |=> !rx_req_n);

   p_multi_rx_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && rx_count == '0 && !rx_trig_hit && !rx_tmo_hit) |=> rx_req_n);

   p_multi_tx_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && tx_count == '0) |=> !tx_req_n);

   p_multi_tx_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && tx_count == TXC_W'(TX_DEPTH)) |=> tx_req_n);

   p_multi_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && $stable(fifo_en) && $stable(dma_sel) && !tx_req_n
       && tx_count != TXC_W'(TX_DEPTH)) |=> !tx_req_n);

   p_mode_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && !($stable(dma_sel) && $stable(fifo_en)) && !rx_trig_hit && !rx_tmo_hit)
      |=> rx_req_n);
endmodule

bind dma_ready_gen dma_ready_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_count    (rx_count),
   .rx_trig_hit (rx_trig_hit),
   .rx_tmo_hit  (rx_tmo_hit),
   .tx_count    (tx_count),
   .fifo_en     (fifo_en),
   .dma_sel     (dma_sel),
   .rx_req_n    (rx_req_n),
   .tx_req_n    (tx_req_n)
);

// File: tb/test_dma_ready_gen.sv
`timescale 1ns/1ps
module test_dma_ready_gen;
   localparam int RX_DEPTH = 16;
   localparam int TX_DEPTH = 16;
   localparam int RXC_W = $clog2(RX_DEPTH + 1);
   localparam int TXC_W = $clog2(TX_DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [RXC_W-1:0] rx_count = '0;
   logic             rx_trig_hit = 1'b0;
   logic             rx_tmo_hit = 1'b0;
   logic [TXC_W-1:0] tx_count = '0;
   logic             fifo_en = 1'b0;
   logic             dma_sel = 1'b0;
   logic             rx_req_n;
   logic             tx_req_n;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   dma_ready_gen #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) i_dma_ready_gen (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_trig_hit(rx_trig_hit),
      .rx_tmo_hit(rx_tmo_hit), .tx_count(tx_count), .fifo_en(fifo_en),
      .dma_sel(dma_sel), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
   );

   task automatic check(input string req, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Inputs are set at a falling edge; one rising edge later the output is sampled.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input int rc, input bit trig, input bit tmo, input int tc);
      rx_count    = RXC_W'(rc);
      rx_trig_hit = trig;
      rx_tmo_hit  = tmo;
      tx_count    = TXC_W'(tc);
      step();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      fifo_en = 1'b1; dma_sel = 1'b1; rx_count = 5; tx_count = 0;
      @(negedge clk);
      check("R1 rx idle in reset", rx_req_n, 1'b1);
      check("R1 tx idle in reset", tx_req_n, 1'b1);
      fifo_en = 1'b0; dma_sel = 1'b0; rx_count = 0; tx_count = 3;
      @(negedge clk);
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_single_rx();
      fifo_en = 1'b1; dma_sel = 1'b0;
      drive(0, 0, 0, 3);
      check("R3 single rx empty", rx_req_n, 1'b1);
      drive(1, 0, 0, 3);
      check("R3 single rx one char", rx_req_n, 1'b0);
      drive(9, 0, 0, 3);
      check("R3 single rx many", rx_req_n, 1'b0);
      drive(0, 1, 1, 3);
      check("R3 single rx drained, flags ignored", rx_req_n, 1'b1);
   endtask

   task automatic t_single_tx();
      fifo_en = 1'b1; dma_sel = 1'b0;
      drive(0, 0, 0, 0);
      check("R4 single tx empty", tx_req_n, 1'b0);
      drive(0, 0, 0, 1);
      check("R4 single tx one char", tx_req_n, 1'b1);
      drive(0, 0, 0, 0);
      check("R4 single tx empty again", tx_req_n, 1'b0);
   endtask

   task automatic t_compat();
      fifo_en = 1'b0; dma_sel = 1'b1;
      drive(1, 0, 0, 1);
      check("R8 compat rx one char", rx_req_n, 1'b0);
      check("R8 compat tx busy", tx_req_n, 1'b1);
      drive(0, 1, 0, 0);
      check("R8 compat rx empty despite trigger", rx_req_n, 1'b1);
      check("R8 compat tx empty", tx_req_n, 1'b0);
      fifo_en = 1'b0; dma_sel = 1'b0;
      drive(1, 0, 0, 0);
      check("R2 both bits clear is single", rx_req_n, 1'b0);
   endtask

   task automatic t_multi_rx();
      fifo_en = 1'b1; dma_sel = 1'b1;
      drive(3, 0, 0, 5);
      drive(3, 0, 0, 5);
      check("R2 multi rx below trigger idle", rx_req_n, 1'b1);
      drive(8, 1, 0, 5);
      check("R5 multi rx trigger", rx_req_n, 1'b0);
      drive(3, 0, 0, 5);
      check("R6 multi rx held below trigger", rx_req_n, 1'b0);
      drive(1, 0, 0, 5);
      check("R6 multi rx held last char", rx_req_n, 1'b0);
      drive(0, 0, 0, 5);
      check("R6 multi rx drained", rx_req_n, 1'b1);
      drive(2, 0, 0, 5);
      check("R6 multi rx stays idle", rx_req_n, 1'b1);
      drive(2, 0, 1, 5);
      check("R5 multi rx timeout", rx_req_n, 1'b0);
      drive(1, 0, 0, 5);
      check("R6 multi rx held after timeout", rx_req_n, 1'b0);
      drive(0, 0, 0, 5);
      check("R6 multi rx drained after timeout", rx_req_n, 1'b1);
   endtask

   task automatic t_multi_tx();
      fifo_en = 1'b1; dma_sel = 1'b1;
      drive(0, 0, 0, 0);
      check("R7 multi tx empty", tx_req_n, 1'b0);
      drive(0, 0, 0, 5);
      check("R7 multi tx held", tx_req_n, 1'b0);
      drive(0, 0, 0, TX_DEPTH - 1);
      check("R7 multi tx held one short", tx_req_n, 1'b0);
      drive(0, 0, 0, TX_DEPTH);
      check("R7 multi tx full", tx_req_n, 1'b1);
      drive(0, 0, 0, 5);
      check("R7 multi tx stays idle", tx_req_n, 1'b1);
      drive(0, 0, 0, 0);
      check("R7 multi tx empty again", tx_req_n, 1'b0);
   endtask

   task automatic t_mode_change();
      fifo_en = 1'b1; dma_sel = 1'b1;
      drive(8, 1, 0, 5);
      drive(5, 0, 0, 5);
      check("R6 latched before mode change", rx_req_n, 1'b0);
      dma_sel = 1'b0;
      drive(5, 0, 0, 5);
      check("R3 single with chars", rx_req_n, 1'b0);
      dma_sel = 1'b1;
      drive(5, 0, 0, 5);
      check("R9 dma_sel change clears latch", rx_req_n, 1'b1);
      drive(8, 1, 0, 5);
      drive(5, 0, 0, 5);
      fifo_en = 1'b0;
      drive(5, 0, 0, 5);
      fifo_en = 1'b1;
      drive(5, 0, 0, 5);
      check("R9 fifo_en change clears latch", rx_req_n, 1'b1);
      drive(5, 0, 1, 5);
      check("R9 re-evaluated after change", rx_req_n, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_single_rx();
      t_single_tx();
      t_compat();
      t_multi_rx();
      t_multi_tx();
      t_mode_change();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule